// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells the issue logic of an out-of-order core whether a memory instruction should wait for an older store that is still in flight, and if so, which one. Instructions whose accesses have collided before are grouped into a shared store set. A lookup by instruction PC returns the sequence number of the most recently fetched store in that set, so the scheduler can hold the instruction until that exact store has issued.

Two tables do the work. A PC-indexed table maps an instruction to a set identifier, and a table indexed by set identifier holds the newest fetched store of each set. A memory-order violation report places the offending load and store in one set. An inserted store becomes the newest store of its set. Issue and squash notifications retire or cancel tracked stores. A small in-flight store list keeps the set identifier of each tracked store, so retirement and cancellation need no PC. Lookups are combinational from registered state. Every update takes effect at the next clock edge.

Top module: `mdp_store_sets`

## Requirements
- R1: After reset, every valid bit in both tables and in the in-flight store list is clear. Every lookup returns `lk_hit`=0 and `lk_dep_seq`=0 until a new set is formed.
- R2: The set table index is `(pc >> OFF_BITS) & (SSIT_DEPTH-1)`. With the defaults (2, 64), PCs that differ only in bits [1:0], or by a multiple of 256, share an entry.
- R3: A violation in which neither PC has a valid set identifier gives both the identifier `(store_pc ^ (store_pc >> 10)) % LFST_DEPTH`.
- R4: A violation in which exactly one PC has a valid identifier gives that identifier to the other PC. When both have one, both take the numerically smaller identifier.
- R5: A store insert whose PC has no valid set identifier changes neither table and takes no in-flight list slot.
- R6: A store insert whose PC has a valid identifier writes its sequence number into that set's newest-store entry. A lookup returns the newest store of the PC's set with `lk_hit`=1, or 0 with `lk_hit`=0 when either table entry on the path is invalid.
- R7: Issuing a tracked store frees its list slot. It clears the newest-store entry of its set only when that entry still holds the issued sequence number.
- R8: A squash with thread T and sequence S cancels every tracked store of thread T with a sequence number strictly greater than S (unsigned compare) and clears any newest-store entry still holding one of them. Stores of other threads and stores not younger than S stay.
- R9: When all SB_DEPTH list slots are occupied, a further insert with a valid set still updates the newest-store entry but is not tracked. Its later issue or squash leaves the tables unchanged.
- R10: A lookup in the same cycle as an insert into the same set returns the value from before the insert. The new store is visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_valid | input | 1 | Ordering violation report this cycle |
| viol_load_pc | input | PC_W | PC of the younger load in the violation |
| viol_store_pc | input | PC_W | PC of the older store in the violation |
| st_ins_valid | input | 1 | A store is fetched this cycle |
| st_ins_pc | input | PC_W | PC of the fetched store |
| st_ins_seq | input | SEQ_W | Sequence number of the fetched store |
| st_ins_tid | input | TID_W | Thread of the fetched store |
| lk_pc | input | PC_W | PC of the instruction being checked |
| lk_hit | output | 1 | A producer store is predicted |
| lk_dep_seq | output | SEQ_W | Sequence number of the predicted producer store, 0 if none |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_seq | input | SEQ_W | Sequence number of the issuing instruction |
| iss_is_store | input | 1 | The issuing instruction is a store |
| sq_valid | input | 1 | Squash request this cycle |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Oldest surviving sequence number of that thread |

## Verification
Set formation is driven through all three merge cases. The PCs are picked so that the hashed identifier, the load's identifier and the store's identifier differ, so a wrong merge choice shows up as a lookup returning another set's store. Issue is exercised both on a store that is still the newest in its set and on one that has been overtaken, which separates a matching clear from an unconditional one. Squashes hit a mixed list of threads and ages, including the exact boundary sequence number, to tell the strict younger-than test and the thread filter apart. A full list and a same-cycle insert and lookup pin down the untracked-store and read-before-write orderings.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  localparam int DEF_PC_W   = 32;
  localparam int DEF_SEQ_W  = 16;
  localparam int DEF_TID_W  = 1;
  localparam int HASH_SHIFT = 10;

  // set identifier hash of a store PC, reduced modulo the set count
  function automatic int unsigned set_hash(input logic [63:0] pc, input int unsigned sets);
    logic [63:0] mix;
    mix = pc ^ (pc >> HASH_SHIFT);
    return int'(mix % 64'(sets));
  endfunction
endpackage

// File: rtl/mdp_ssit.sv
module mdp_ssit #(
  parameter int PC_W       = 32,
  parameter int DEPTH      = 64,
  parameter int OFF_BITS   = 2,
  parameter int SETS       = 16,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int SSID_W    = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   a_pc,
  output logic              a_hit,
  output logic [SSID_W-1:0] a_ssid,
  input  logic [PC_W-1:0]   b_pc,
  output logic              b_hit,
  output logic [SSID_W-1:0] b_ssid,
  input  logic              viol_valid,
  input  logic [PC_W-1:0]   viol_load_pc,
  input  logic [PC_W-1:0]   viol_store_pc
);
  import mdp_pkg::*;

  logic [SSID_W-1:0] id_mem [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return IDX_W'(pc >> OFF_BITS);
  endfunction

  logic [IDX_W-1:0]  a_idx, b_idx, l_idx, s_idx;
  logic              l_ok, s_ok;
  logic [SSID_W-1:0] l_id, s_id, fresh_id, merged_id;

  always_comb begin
    a_idx  = idx_of(a_pc);
    b_idx  = idx_of(b_pc);
    l_idx  = idx_of(viol_load_pc);
    s_idx  = idx_of(viol_store_pc);
    a_hit  = vld_q[a_idx];
    a_ssid = id_mem[a_idx];
    b_hit  = vld_q[b_idx];
    b_ssid = id_mem[b_idx];
    l_ok   = vld_q[l_idx];
    s_ok   = vld_q[s_idx];
    l_id   = id_mem[l_idx];
    s_id   = id_mem[s_idx];
    fresh_id = SSID_W'(set_hash(64'(viol_store_pc), SETS));
    unique case ({l_ok, s_ok})
      2'b00:   merged_id = fresh_id;
      2'b10:   merged_id = l_id;
      2'b01:   merged_id = s_id;
      default: merged_id = (l_id < s_id) ? l_id : s_id;
    endcase
  end

  // identifier storage: no reset, written only on violations
  always_ff @(posedge clk) begin
    if (viol_valid && !rst) begin
      id_mem[l_idx] <= merged_id;
      id_mem[s_idx] <= merged_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (viol_valid) begin
      vld_q[l_idx] <= 1'b1;
      vld_q[s_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/mdp_lfst.sv
module mdp_lfst #(
  parameter int SEQ_W     = 16,
  parameter int SETS      = 16,
  parameter int SB_DEPTH  = 4,
  localparam int SSID_W   = $clog2(SETS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [SSID_W-1:0]                rd_ssid,
  output logic                             rd_vld,
  output logic [SEQ_W-1:0]                 rd_seq,
  input  logic                             wr_en,
  input  logic [SSID_W-1:0]                wr_ssid,
  input  logic [SEQ_W-1:0]                 wr_seq,
  input  logic                             iss_en,
  input  logic [SSID_W-1:0]                iss_ssid,
  input  logic [SEQ_W-1:0]                 iss_seq,
  input  logic [SB_DEPTH-1:0]              kill,
  input  logic [SB_DEPTH-1:0][SSID_W-1:0]  ent_ssid,
  input  logic [SB_DEPTH-1:0][SEQ_W-1:0]   ent_seq,
  output logic [SETS-1:0]                  vld
);
  logic [SEQ_W-1:0] seq_mem [SETS];
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  clr;

  assign rd_vld = vld_q[rd_ssid];
  assign rd_seq = seq_mem[rd_ssid];
  assign vld    = vld_q;

  // an entry is dropped only if it still names the retired/cancelled store
  always_comb begin
    clr = '0;
    for (int e = 0; e < SETS; e++) begin
      if (iss_en && iss_ssid == SSID_W'(e) && iss_seq == seq_mem[e])
        clr[e] = 1'b1;
      for (int k = 0; k < SB_DEPTH; k++) begin
        if (kill[k] && ent_ssid[k] == SSID_W'(e) && ent_seq[k] == seq_mem[e])
          clr[e] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rst) seq_mem[wr_ssid] <= wr_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int e = 0; e < SETS; e++) begin
        if (wr_en && wr_ssid == SSID_W'(e)) vld_q[e] <= 1'b1;
        else if (clr[e])                    vld_q[e] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdp_inflight.sv
module mdp_inflight #(
  parameter int SEQ_W    = 16,
  parameter int SSID_W   = 4,
  parameter int TID_W    = 1,
  parameter int DEPTH    = 4,
  localparam int SB_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            alloc_en,
  input  logic [SEQ_W-1:0]                alloc_seq,
  input  logic [SSID_W-1:0]               alloc_ssid,
  input  logic [TID_W-1:0]                alloc_tid,
  input  logic                            iss_en,
  input  logic [SEQ_W-1:0]                iss_seq,
  output logic                            iss_found,
  output logic [SSID_W-1:0]               iss_ssid,
  input  logic                            sq_en,
  input  logic [TID_W-1:0]                sq_tid,
  input  logic [SEQ_W-1:0]                sq_seq,
  output logic [DEPTH-1:0]                kill,
  output logic [DEPTH-1:0]                ent_vld,
  output logic [DEPTH-1:0][SEQ_W-1:0]     ent_seq,
  output logic [DEPTH-1:0][SSID_W-1:0]    ent_ssid,
  output logic [DEPTH-1:0][TID_W-1:0]     ent_tid
);
  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;
  logic [DEPTH-1:0][SSID_W-1:0] ssid_q;
  logic [DEPTH-1:0][TID_W-1:0]  tid_q;
  logic [DEPTH-1:0]             iss_sel;
  logic [SB_W-1:0]              free_idx;
  logic                         have_free;

  assign ent_vld  = vld_q;
  assign ent_seq  = seq_q;
  assign ent_ssid = ssid_q;
  assign ent_tid  = tid_q;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        have_free = 1'b1;
        free_idx  = SB_W'(i);
      end
    end
    iss_sel   = '0;
    iss_found = 1'b0;
    iss_ssid  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!iss_found && iss_en && vld_q[i] && seq_q[i] == iss_seq) begin
        iss_found  = 1'b1;
        iss_sel[i] = 1'b1;
        iss_ssid   = ssid_q[i];
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_kill
      assign kill[g] = sq_en && vld_q[g] && tid_q[g] == sq_tid && seq_q[g] > sq_seq;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (alloc_en && have_free && !rst) begin
      seq_q[free_idx]  <= alloc_seq;
      ssid_q[free_idx] <= alloc_ssid;
      tid_q[free_idx]  <= alloc_tid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i] || iss_sel[i]) vld_q[i] <= 1'b0;
      end
      if (alloc_en && have_free) vld_q[free_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/mdp_store_sets.sv
module mdp_store_sets #(
  parameter int PC_W       = mdp_pkg::DEF_PC_W,
  parameter int SEQ_W      = mdp_pkg::DEF_SEQ_W,
  parameter int TID_W      = mdp_pkg::DEF_TID_W,
  parameter int SSIT_DEPTH = 64,
  parameter int LFST_DEPTH = 16,
  parameter int OFF_BITS   = 2,
  parameter int SB_DEPTH   = 4,
  localparam int SSID_W    = $clog2(LFST_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              viol_valid,
  input  logic [PC_W-1:0]   viol_load_pc,
  input  logic [PC_W-1:0]   viol_store_pc,
  input  logic              st_ins_valid,
  input  logic [PC_W-1:0]   st_ins_pc,
  input  logic [SEQ_W-1:0]  st_ins_seq,
  input  logic [TID_W-1:0]  st_ins_tid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_hit,
  output logic [SEQ_W-1:0]  lk_dep_seq,
  input  logic              iss_valid,
  input  logic [SEQ_W-1:0]  iss_seq,
  input  logic              iss_is_store,
  input  logic              sq_valid,
  input  logic [TID_W-1:0]  sq_tid,
  input  logic [SEQ_W-1:0]  sq_seq
);
  logic                              lk_set_ok, lk_store_ok;
  logic [SSID_W-1:0]                 lk_ssid;
  logic [SEQ_W-1:0]                  lk_store_seq;
  logic                              ins_hit;
  logic [SSID_W-1:0]                 ins_ssid;
  logic                              ins_go;
  logic                              iss_found;
  logic [SSID_W-1:0]                 iss_ssid;
  logic [SB_DEPTH-1:0]               buf_kill, buf_vld;
  logic [SB_DEPTH-1:0][SEQ_W-1:0]    buf_seq;
  logic [SB_DEPTH-1:0][SSID_W-1:0]   buf_ssid;
  logic [SB_DEPTH-1:0][TID_W-1:0]    buf_tid;
  logic [LFST_DEPTH-1:0]             lfst_vld;

  assign ins_go = st_ins_valid && ins_hit;

  mdp_ssit #(
    .PC_W(PC_W), .DEPTH(SSIT_DEPTH), .OFF_BITS(OFF_BITS), .SETS(LFST_DEPTH)
  ) u_ssit (
    .clk(clk), .rst(rst),
    .a_pc(lk_pc), .a_hit(lk_set_ok), .a_ssid(lk_ssid),
    .b_pc(st_ins_pc), .b_hit(ins_hit), .b_ssid(ins_ssid),
    .viol_valid(viol_valid), .viol_load_pc(viol_load_pc), .viol_store_pc(viol_store_pc)
  );

  mdp_inflight #(
    .SEQ_W(SEQ_W), .SSID_W(SSID_W), .TID_W(TID_W), .DEPTH(SB_DEPTH)
  ) u_inflight (
    .clk(clk), .rst(rst),
    .alloc_en(ins_go), .alloc_seq(st_ins_seq), .alloc_ssid(ins_ssid), .alloc_tid(st_ins_tid),
    .iss_en(iss_valid && iss_is_store), .iss_seq(iss_seq),
    .iss_found(iss_found), .iss_ssid(iss_ssid),
    .sq_en(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .kill(buf_kill), .ent_vld(buf_vld), .ent_seq(buf_seq), .ent_ssid(buf_ssid), .ent_tid(buf_tid)
  );

  mdp_lfst #(
    .SEQ_W(SEQ_W), .SETS(LFST_DEPTH), .SB_DEPTH(SB_DEPTH)
  ) u_lfst (
    .clk(clk), .rst(rst),
    .rd_ssid(lk_ssid), .rd_vld(lk_store_ok), .rd_seq(lk_store_seq),
    .wr_en(ins_go), .wr_ssid(ins_ssid), .wr_seq(st_ins_seq),
    .iss_en(iss_found), .iss_ssid(iss_ssid), .iss_seq(iss_seq),
    .kill(buf_kill), .ent_ssid(buf_ssid), .ent_seq(buf_seq),
    .vld(lfst_vld)
  );

  assign lk_hit     = lk_set_ok && lk_store_ok;
  assign lk_dep_seq = lk_hit ? lk_store_seq : '0;
endmodule

// File: rtl/mdp_store_sets_chk.sv
module mdp_store_sets_chk #(
  parameter int SEQ_W    = 16,
  parameter int TID_W    = 1,
  parameter int SETS     = 16,
  parameter int SB_DEPTH = 4,
  localparam int SSID_W  = $clog2(SETS)
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            st_ins_valid,
  input logic                            iss_valid,
  input logic                            iss_is_store,
  input logic                            sq_valid,
  input logic [TID_W-1:0]                sq_tid,
  input logic [SEQ_W-1:0]                sq_seq,
  input logic                            lk_hit,
  input logic                            ins_hit,
  input logic [SSID_W-1:0]               ins_ssid,
  input logic                            iss_found,
  input logic [SETS-1:0]                 lfst_vld,
  input logic [SB_DEPTH-1:0]             buf_vld,
  input logic [SB_DEPTH-1:0][TID_W-1:0]  buf_tid,
  input logic [SB_DEPTH-1:0][SEQ_W-1:0]  buf_seq
);
  logic             sq_q, ins_q;
  logic [TID_W-1:0] tid_q;
  logic [SEQ_W-1:0] seq_q;
  logic             young_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_q  <= 1'b0;
      ins_q <= 1'b0;
      tid_q <= '0;
      seq_q <= '0;
    end else begin
      sq_q  <= sq_valid;
      ins_q <= st_ins_valid;
      tid_q <= sq_tid;
      seq_q <= sq_seq;
    end
  end

  always_comb begin
    young_left = 1'b0;
    for (int k = 0; k < SB_DEPTH; k++) begin
      if (sq_q && !ins_q && buf_vld[k] && buf_tid[k] == tid_q && buf_seq[k] > seq_q)
        young_left = 1'b1;
    end
  end

  // R1
  post_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // R5
  no_set_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (st_ins_valid && !ins_hit && !iss_valid && !sq_valid) |=> ($stable(lfst_vld) && $stable(buf_vld)));

  // R6
  insert_marks_set_chk: assert property (@(posedge clk) disable iff (rst)
    (st_ins_valid && ins_hit) |=> lfst_vld[$past(ins_ssid)]);

  // R7
  issue_frees_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_is_store && iss_found && !st_ins_valid && !sq_valid)
      |=> ($countones(buf_vld) + 1 == $countones($past(buf_vld))));

  // R8
  squash_purge_chk: assert property (@(posedge clk) disable iff (rst)
    !young_left);

  // R9
  full_no_track_chk: assert property (@(posedge clk) disable iff (rst)
    (st_ins_valid && ins_hit && (&buf_vld) && !iss_valid && !sq_valid) |=> $stable(buf_vld));
endmodule

bind mdp_store_sets mdp_store_sets_chk #(
  .SEQ_W(SEQ_W), .TID_W(TID_W), .SETS(LFST_DEPTH), .SB_DEPTH(SB_DEPTH)
) u_chk (
  .clk(clk), .rst(rst),
  .st_ins_valid(st_ins_valid), .iss_valid(iss_valid), .iss_is_store(iss_is_store),
  .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
  .lk_hit(lk_hit), .ins_hit(ins_hit), .ins_ssid(ins_ssid), .iss_found(iss_found),
  .lfst_vld(lfst_vld), .buf_vld(buf_vld), .buf_tid(buf_tid), .buf_seq(buf_seq)
);

// File: tb/mdp_store_sets_test.sv
module mdp_store_sets_test;
  localparam int PC_W = 32;
  localparam int SEQ_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             viol_valid = 1'b0;
  logic [PC_W-1:0]  viol_load_pc = '0, viol_store_pc = '0;
  logic             st_ins_valid = 1'b0;
  logic [PC_W-1:0]  st_ins_pc = '0;
  logic [SEQ_W-1:0] st_ins_seq = '0;
  logic [0:0]       st_ins_tid = '0;
  logic [PC_W-1:0]  lk_pc = '0;
  logic             lk_hit;
  logic [SEQ_W-1:0] lk_dep_seq;
  logic             iss_valid = 1'b0;
  logic [SEQ_W-1:0] iss_seq = '0;
  logic             iss_is_store = 1'b0;
  logic             sq_valid = 1'b0;
  logic [0:0]       sq_tid = '0;
  logic [SEQ_W-1:0] sq_seq = '0;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  bit    lk_en = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  // PCs: A hash 4 idx 1, B idx 0, C hash 12 idx 3, D idx 4, E idx 7, F idx 8, U idx 16
  localparam logic [31:0] PA = 32'h104, PB = 32'h200, PC_ = 32'h10C, PD = 32'h310;
  localparam logic [31:0] PE = 32'h41C, PF = 32'h120, PU = 32'h540;

  always #4 clk = ~clk;

  mdp_store_sets uut (
    .clk(clk), .rst(rst),
    .viol_valid(viol_valid), .viol_load_pc(viol_load_pc), .viol_store_pc(viol_store_pc),
    .st_ins_valid(st_ins_valid), .st_ins_pc(st_ins_pc), .st_ins_seq(st_ins_seq), .st_ins_tid(st_ins_tid),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_dep_seq(lk_dep_seq),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_is_store(iss_is_store),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq)
  );

  // monitor: compares the lookup result late in each low phase
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (lk_en && exp_q.size() > 0) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (lk_dep_seq !== SEQ_W'(e) || lk_hit !== (e != 0)) begin
          bad++;
          $display("FAIL %s: lookup pc=%h got seq=%0d hit=%0b, expected seq=%0d hit=%0b",
                   t, lk_pc, lk_dep_seq, lk_hit, e, (e != 0));
        end
      end
    end
  end

  task automatic quiet();
    viol_valid = 1'b0; st_ins_valid = 1'b0; iss_valid = 1'b0;
    iss_is_store = 1'b0; sq_valid = 1'b0; lk_en = 1'b0;
  endtask

  task automatic t_idle();
    @(negedge clk); quiet();
  endtask

  task automatic t_viol(input logic [31:0] lpc, input logic [31:0] spc);
    @(negedge clk); quiet();
    viol_valid = 1'b1; viol_load_pc = lpc; viol_store_pc = spc;
  endtask

  task automatic t_ins(input logic [31:0] pc, input int seq, input int tid);
    @(negedge clk); quiet();
    st_ins_valid = 1'b1; st_ins_pc = pc; st_ins_seq = SEQ_W'(seq); st_ins_tid = 1'(tid);
  endtask

  task automatic t_iss(input int seq);
    @(negedge clk); quiet();
    iss_valid = 1'b1; iss_is_store = 1'b1; iss_seq = SEQ_W'(seq);
  endtask

  task automatic t_sq(input int tid, input int seq);
    @(negedge clk); quiet();
    sq_valid = 1'b1; sq_tid = 1'(tid); sq_seq = SEQ_W'(seq);
  endtask

  // driver: pushes the expected lookup result for the monitor
  task automatic t_look(input logic [31:0] pc, input int exp, input string tag);
    @(negedge clk); quiet();
    lk_pc = pc; lk_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic t_ins_look(input logic [31:0] ipc, input int seq,
                            input logic [31:0] lpc, input int exp, input string tag);
    @(negedge clk); quiet();
    st_ins_valid = 1'b1; st_ins_pc = ipc; st_ins_seq = SEQ_W'(seq); st_ins_tid = 1'b0;
    lk_pc = lpc; lk_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic t_reset();
    @(negedge clk); quiet(); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    t_look(PB, 0, "R1");
    t_look(PA, 0, "R1");
    t_look(PU, 0, "R1");
    // R3: fresh set from store hash
    t_viol(PB, PA);
    t_ins(PA, 10, 0);
    t_look(PB, 10, "R3");
    t_look(PA, 10, "R6");
    // R2: index aliasing
    t_look(PB + 32'h1, 10, "R2");
    t_look(PB + 32'h100, 10, "R2");
    t_iss(10);
    t_look(PB, 0, "R7");
    t_viol(PD, PC_);
    t_ins(PC_, 20, 0);
    t_look(PD, 20, "R3");
    t_iss(20);
    // R4: both valid, smaller id (4) wins
    t_viol(PD, PA);
    t_ins(PC_, 21, 0);
    t_look(PD, 0, "R4");
    t_look(PC_, 21, "R4");
    t_ins(PA, 22, 0);
    t_look(PD, 22, "R4");
    t_iss(21);
    t_iss(22);
    // R4: only store valid
    t_viol(PE, PC_);
    t_ins(PC_, 30, 0);
    t_look(PE, 30, "R4");
    t_iss(30);
    // R4: only load valid
    t_viol(PB, PF);
    t_ins(PF, 40, 0);
    t_look(PB, 40, "R4");
    t_iss(40);
    t_look(PB, 0, "R7");
    // R5: store without set
    t_ins(PU, 99, 0);
    t_look(PU, 0, "R5");
    // R6 and R7: newer store survives older issue
    t_ins(PA, 50, 0);
    t_ins(PF, 51, 0);
    t_look(PD, 51, "R6");
    t_iss(50);
    t_look(PB, 51, "R7");
    t_iss(51);
    t_look(PB, 0, "R7");
    // R10: same-cycle insert and lookup
    t_ins_look(PA, 60, PB, 0, "R10");
    t_look(PB, 60, "R10");
    t_iss(60);
    // R8: squash by thread and age
    t_ins(PA, 70, 0);
    t_ins(PC_, 71, 1);
    t_ins(PF, 72, 0);
    t_sq(0, 71);
    t_look(PB, 0, "R8");
    t_look(PE, 71, "R8");
    t_sq(1, 70);
    t_look(PE, 0, "R8");
    t_iss(70);
    t_ins(PA, 80, 0);
    t_sq(0, 80);
    t_look(PB, 80, "R8");
    t_sq(1, 0);
    t_look(PB, 80, "R8");
    t_iss(80);
    // R9: full list, fifth store untracked
    for (int s = 90; s < 95; s++) t_ins(PA, s, 0);
    t_iss(94);
    t_look(PB, 94, "R9");
    for (int s = 90; s < 94; s++) t_iss(s);
    t_look(PB, 94, "R9");
    // R1: reset clears live state
    t_reset();
    t_look(PB, 0, "R1");
    t_look(PC_, 0, "R1");
    t_idle();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, got no completion, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule